// File: doc/BRIEF.md
# Twin LIFO Stacks in One Shared Memory

This block keeps two independent last-in first-out stacks inside a single two-port memory. The memory of `DEPTH` words is cut into two fixed halves: stack 0 lives at addresses 0 to `DEPTH/2-1`, and stack 1 lives at `DEPTH/2` to `DEPTH-1`. Each stack drives its own memory port from its own pointer. Sharing one memory saves area when neither stack needs the whole depth.

Neither stack has a separate read address. The registered read data of each port is the stack's visible top, so each port works in write-first mode. A value pushed in one cycle shows at the top output after the same clock edge that stores it. A pop reads the element beneath the old top. A push and a pop in the same cycle overwrite the top in place. Each stack reports its element count, full and empty flags, and a one-cycle error pulse when a command is refused.

Top module: `twin_lifo`

## Requirements
- R1: After reset both stacks report level 0, empty high, full low, error low and a top value of zero.
- R2: A push alone on a stack that is not full raises its level by one. From the next cycle its top output shows the pushed word.
- R3: A pop alone on a stack that is not empty lowers its level by one. From the next cycle its top output shows the word pushed before the removed one.
- R4: A push together with a pop on a non-empty stack leaves the level unchanged. From the next cycle the top output shows the new word in place of the old top.
- R5: Full is high exactly when the level equals `DEPTH/2`. A push without a pop on a full stack is ignored: the level and the top output stay unchanged.
- R6: A pop on an empty stack, with or without a push, is ignored: the level stays 0 and the top output stays zero.
- R7: Empty is high exactly when the level is 0. While a stack is empty its top output reads zero.
- R8: The two stacks are independent. Commands on one stack never change the level, flags or top output of the other, because stack 0 only ever addresses the lower half of the memory and stack 1 only the upper half.
- R9: A refused command (R5 or R6) raises that stack's error output for exactly the following cycle. The error output is low after any accepted or idle cycle.
- R10: With no command, a stack's level, flags and top output hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low synchronous reset |
| push0 | input | 1 | Push request, stack 0 |
| pop0 | input | 1 | Pop request, stack 0 |
| din0 | input | WIDTH | Word to push, stack 0 |
| top0 | output | WIDTH | Current top of stack 0 (zero when empty) |
| level0 | output | CNT_W | Element count, stack 0 |
| full0 | output | 1 | Stack 0 holds DEPTH/2 words |
| empty0 | output | 1 | Stack 0 holds no words |
| err0 | output | 1 | One-cycle refused-command pulse, stack 0 |
| push1 | input | 1 | Push request, stack 1 |
| pop1 | input | 1 | Pop request, stack 1 |
| din1 | input | WIDTH | Word to push, stack 1 |
| top1 | output | WIDTH | Current top of stack 1 (zero when empty) |
| level1 | output | CNT_W | Element count, stack 1 |
| full1 | output | 1 | Stack 1 holds DEPTH/2 words |
| empty1 | output | 1 | Stack 1 holds no words |
| err1 | output | 1 | One-cycle refused-command pulse, stack 1 |

## Verification
On every cycle the assertions check the pointer arithmetic. They cover increment on an accepted push, hold on a swap, idle or refused command, exclusive full and empty flags, and the error pulse timing. They also check that each port's read data equals the word it wrote in the cycle before, and that every memory access stays inside its own stack's half. Only the bench's scenarios can show the data the stacks return. That covers the correct element reappearing after a chain of pops, the in-place replacement, the zero top when empty, and that heavy traffic on one stack leaves the other's contents intact. A reference model of both stacks, driven by seeded random traffic mixed with directed fill, drain and refusal sequences, supplies the expected values.

// File: rtl/twin_lifo_pkg.sv
package twin_lifo_pkg;

  // strobes handed from a stack controller to its memory port
  typedef struct packed {
    logic portEn;  // access the memory this cycle
    logic portWe;  // the access is a write (read data follows write data)
  } memStrobe_t;

  // decoded command of one stack for one cycle
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP,
    OP_REFUSE
  } stackOp_t;

endpackage

// File: rtl/twin_lifo_ctrl.sv
module twin_lifo_ctrl
  import twin_lifo_pkg::*;
#(
  parameter int HALF   = 8,
  parameter int BASE   = 0,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] portAddr,
  output logic [CNT_W-1:0]  level,
  output logic              isFull,
  output logic              isEmpty,
  output logic              errPulse
);

  localparam logic [CNT_W-1:0]  LIMIT   = CNT_W'(HALF);
  localparam logic [ADDR_W-1:0] BASE_AD = ADDR_W'(BASE);

  stackOp_t         op;
  logic [CNT_W-1:0] levelNext;
  logic [CNT_W-1:0] slot;
  logic             errNext;

  assign isFull  = (level == LIMIT);
  assign isEmpty = (level == '0);

  // command decode
  always_comb begin
    op = OP_IDLE;
    unique case ({pushReq, popReq})
      2'b10:   op = isFull  ? OP_REFUSE : OP_PUSH;
      2'b01:   op = isEmpty ? OP_REFUSE : OP_POP;
      2'b11:   op = isEmpty ? OP_REFUSE : OP_SWAP;
      default: op = OP_IDLE;
    endcase
  end

  // pointer update, slot selection and port strobes
  always_comb begin
    levelNext     = level;
    slot          = '0;
    strobe.portEn = 1'b0;
    strobe.portWe = 1'b0;
    errNext       = 1'b0;
    unique case (op)
      OP_PUSH: begin
        levelNext     = level + 1'b1;
        slot          = level;           // new top index
        strobe.portEn = 1'b1;
        strobe.portWe = 1'b1;
      end
      OP_SWAP: begin
        slot          = level - 1'b1;    // overwrite current top
        strobe.portEn = 1'b1;
        strobe.portWe = 1'b1;
      end
      OP_POP: begin
        levelNext = level - 1'b1;
        if (level > CNT_W'(1)) begin
          slot          = level - CNT_W'(2);  // element beneath
          strobe.portEn = 1'b1;
        end
      end
      OP_REFUSE: errNext = 1'b1;
      default: ;
    endcase
  end

  assign portAddr = BASE_AD + ADDR_W'(slot);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level    <= '0;
      errPulse <= 1'b0;
    end else begin
      level    <= levelNext;
      errPulse <= errNext;
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    level <= LIMIT);                                                  // R5
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));                                            // R7
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && !isFull) |=> level == $past(level) + 1'b1); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !isEmpty) |=> level == $past(level) - 1'b1); // R3
  AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq && !isEmpty) |=> $stable(level));              // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && isFull) |=> (errPulse && $stable(level))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && isEmpty) |=> (errPulse && level == '0));               // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!pushReq && !popReq) |=> ($stable(level) && !errPulse));         // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !pushReq && !popReq) |=> !errPulse);                 // R9

endmodule

// File: rtl/twin_lifo_mem.sv
module twin_lifo_mem
  import twin_lifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int NPORT  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe [NPORT],
  input  logic [ADDR_W-1:0] addr   [NPORT],
  input  logic [WIDTH-1:0]  wdata  [NPORT],
  output logic [WIDTH-1:0]  rdata  [NPORT]
);

  logic [WIDTH-1:0] store [DEPTH];

  // storage: each port writes only inside its own region, so no collisions
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (strobe[p].portEn && strobe[p].portWe)
        store[addr[p]] <= wdata[p];
    end
  end

  // write-first read registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NPORT; p++) rdata[p] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (strobe[p].portEn)
          rdata[p] <= strobe[p].portWe ? wdata[p] : store[addr[p]];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[p].portEn && strobe[p].portWe) |=> rdata[p] == $past(wdata[p])); // R2
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe[p].portEn |=> $stable(rdata[p]));                                // R10
  end

endmodule

// File: rtl/twin_lifo.sv
module twin_lifo
  import twin_lifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  localparam int HALF   = DEPTH / 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push0,
  input  logic             pop0,
  input  logic [WIDTH-1:0] din0,
  output logic [WIDTH-1:0] top0,
  output logic [CNT_W-1:0] level0,
  output logic             full0,
  output logic             empty0,
  output logic             err0,
  input  logic             push1,
  input  logic             pop1,
  input  logic [WIDTH-1:0] din1,
  output logic [WIDTH-1:0] top1,
  output logic [CNT_W-1:0] level1,
  output logic             full1,
  output logic             empty1,
  output logic             err1
);

  localparam int NSTK = 2;

  logic             pushV  [NSTK];
  logic             popV   [NSTK];
  logic [WIDTH-1:0] dinV   [NSTK];
  memStrobe_t       stb    [NSTK];
  logic [ADDR_W-1:0] adr   [NSTK];
  logic [WIDTH-1:0] rd     [NSTK];
  logic [CNT_W-1:0] lvl    [NSTK];
  logic             fullV  [NSTK];
  logic             emptyV [NSTK];
  logic             errV   [NSTK];

  assign pushV[0] = push0;
  assign pushV[1] = push1;
  assign popV[0]  = pop0;
  assign popV[1]  = pop1;
  assign dinV[0]  = din0;
  assign dinV[1]  = din1;

  for (genvar s = 0; s < NSTK; s++) begin : g_stk
    twin_lifo_ctrl #(
      .HALF  (HALF),
      .BASE  (s * HALF),
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) i_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .pushReq (pushV[s]),
      .popReq  (popV[s]),
      .strobe  (stb[s]),
      .portAddr(adr[s]),
      .level   (lvl[s]),
      .isFull  (fullV[s]),
      .isEmpty (emptyV[s]),
      .errPulse(errV[s])
    );

    AST_OWN_REGION: assert property (@(posedge clk) disable iff (!rstN)
      stb[s].portEn |-> (int'(adr[s]) >= s * HALF && int'(adr[s]) < (s + 1) * HALF)); // R8
  end

  twin_lifo_mem #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .NPORT (NSTK),
    .ADDR_W(ADDR_W)
  ) i_mem (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(stb),
    .addr  (adr),
    .wdata (dinV),
    .rdata (rd)
  );

  assign top0   = emptyV[0] ? '0 : rd[0];
  assign top1   = emptyV[1] ? '0 : rd[1];
  assign level0 = lvl[0];
  assign level1 = lvl[1];
  assign full0  = fullV[0];
  assign full1  = fullV[1];
  assign empty0 = emptyV[0];
  assign empty1 = emptyV[1];
  assign err0   = errV[0];
  assign err1   = errV[1];

endmodule

// File: tb/test_twin_lifo.sv
module test_twin_lifo;

  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int CNT_W = $clog2(HALF + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic             rstN;
  logic             push0, pop0, push1, pop1;
  logic [WIDTH-1:0] din0, din1, top0, top1;
  logic [CNT_W-1:0] level0, level1;
  logic             full0, full1, empty0, empty1, err0, err1;

  twin_lifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_twin_lifo (
    .clk(clk), .rstN(rstN),
    .push0(push0), .pop0(pop0), .din0(din0), .top0(top0), .level0(level0),
    .full0(full0), .empty0(empty0), .err0(err0),
    .push1(push1), .pop1(pop1), .din1(din1), .top1(top1), .level1(level1),
    .full1(full1), .empty1(empty1), .err1(err1)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [WIDTH-1:0] mdl [2][HALF];
  int               mcnt [2];
  bit               merr [2];

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expTop(int s);
    return (mcnt[s] == 0) ? 0 : int'(mdl[s][mcnt[s] - 1]);
  endfunction

  // drive one stack's command and advance the reference model
  task automatic setOp(int s, bit ps, bit pp, logic [WIDTH-1:0] d);
    if (s == 0) begin push0 = ps; pop0 = pp; din0 = d; end
    else        begin push1 = ps; pop1 = pp; din1 = d; end
    merr[s] = 1'b0;
    if (ps && pp) begin
      if (mcnt[s] == 0) merr[s] = 1'b1;
      else mdl[s][mcnt[s] - 1] = d;
    end else if (ps) begin
      if (mcnt[s] == HALF) merr[s] = 1'b1;
      else begin mdl[s][mcnt[s]] = d; mcnt[s]++; end
    end else if (pp) begin
      if (mcnt[s] == 0) merr[s] = 1'b1;
      else mcnt[s]--;
    end
  endtask

  task automatic checkAll(string req);
    chk(req, "level0", int'(level0), mcnt[0]);
    chk(req, "top0",   int'(top0),   expTop(0));
    chk(req, "full0",  int'(full0),  int'(mcnt[0] == HALF));
    chk(req, "empty0", int'(empty0), int'(mcnt[0] == 0));
    chk(req, "err0",   int'(err0),   int'(merr[0]));
    chk(req, "level1", int'(level1), mcnt[1]);
    chk(req, "top1",   int'(top1),   expTop(1));
    chk(req, "full1",  int'(full1),  int'(mcnt[1] == HALF));
    chk(req, "empty1", int'(empty1), int'(mcnt[1] == 0));
    chk(req, "err1",   int'(err1),   int'(merr[1]));
  endtask

  task automatic step(string req);
    @(posedge clk);
    @(negedge clk);
    checkAll(req);
  endtask

  task automatic idleBoth(string req);
    setOp(0, 0, 0, '0);
    setOp(1, 0, 0, '0);
    step(req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mcnt[0] = 0; mcnt[1] = 0; merr[0] = 0; merr[1] = 0;
    rstN = 1'b0;
    push0 = 0; pop0 = 0; din0 = '0; push1 = 0; pop1 = 0; din1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");

    // R6: pop and push+pop on empty are refused
    setOp(0, 0, 1, 8'h11); setOp(1, 1, 1, 8'h22); step("R6");
    idleBoth("R9");

    // R2: fill stack 0 while stack 1 stays idle (R8)
    for (int i = 0; i < HALF; i++) begin
      setOp(0, 1, 0, 8'(8'hA0 + i)); setOp(1, 0, 0, '0); step("R2 R8");
    end
    // R5: push on full refused
    setOp(0, 1, 0, 8'hEE); setOp(1, 0, 0, '0); step("R5");
    setOp(0, 1, 0, 8'hEF); setOp(1, 1, 0, 8'h5A); step("R5 R9");
    idleBoth("R10");
    // R4: swap on full stack
    setOp(0, 1, 1, 8'h77); setOp(1, 1, 1, 8'h66); step("R4");
    // R3: drain stack 0 fully
    for (int i = 0; i < HALF; i++) begin
      setOp(0, 0, 1, '0); setOp(1, 0, 0, '0); step("R3 R7");
    end
    setOp(0, 0, 1, '0); setOp(1, 0, 1, '0); step("R6 R7");
    idleBoth("R9");

    // seeded random traffic on both stacks
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < 2; s++) begin
        int r;
        r = int'($urandom % 8);
        case (r)
          0, 1, 2: setOp(s, 1, 0, 8'($urandom));
          3, 4:    setOp(s, 0, 1, 8'($urandom));
          5:       setOp(s, 1, 1, 8'($urandom));
          default: setOp(s, 0, 0, 8'($urandom));
        endcase
      end
      step("R2 R3 R4 R8");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule